// File: doc/BRIEF.md
# I2C Bus Busy/Free Monitor

This block listens to the SCL and SDA wires of a shared I2C bus without ever driving them and tells a local bus master whether it may open a transaction. Both wires pass through a two-flop synchronizer. The block then looks for the two framing conditions. A START is SDA going low while SCL stays high. A STOP is SDA going high while SCL stays high. From these conditions it keeps a bus state that is FREE, BUSY or UNKNOWN. Each detected condition also raises a one-cycle pulse, which can serve as an interrupt source.

The reset behaviour depends on a mode input. If every device on the bus was reset at the same time, the bus is known to be idle and the state starts at FREE. If only this device was reset, another master may be partway through a transfer, so the state starts at UNKNOWN. In UNKNOWN the block times SCL over a fixed window of system clock cycles:

- Any SCL edge seen during the window makes the state BUSY.
- A quiet window makes the state FREE.
- A START or STOP seen during the window settles the state at once.

A local master raises a request and waits for a registered grant. The grant is given only while the bus is FREE, and there is no limit on how long the wait can last. Arbitration and collision handling are outside this block.

Top module: `i2c_bus_watch`

## Requirements
- R1: A START (SDA falls while SCL is high) moves the state to BUSY from any state and raises start_pulse_o for exactly one clock cycle.
- R2: A STOP (SDA rises while SCL is high) moves the state to FREE from any state and raises stop_pulse_o for exactly one clock cycle.
- R3: With all_reset_i = 1, reset places the state in FREE (state_o = 2'b00).
- R4: With all_reset_i = 0, reset places the state in UNKNOWN (state_o = 2'b10). UNKNOWN is never entered other than by reset.
- R5: In UNKNOWN with no SCL edge and no START or STOP, the state becomes FREE on exactly the WIN_CYCLES-th rising clock edge after reset is released.
- R6: An SCL edge that reaches the state logic while the window is still open moves the state to BUSY. A line change driven d cycles after release gives BUSY when d <= WIN_CYCLES-3, and otherwise the state is FREE.
- R7: A START or STOP seen while in UNKNOWN overrides the window at once, giving BUSY or FREE respectively.
- R8: grant_o is high only while req_i is high and the state is FREE. It rises and falls on the same clock edge as the state enters or leaves FREE, and a request outside FREE waits with no time limit.
- R9: state_o encodes FREE as 2'b00, BUSY as 2'b01 and UNKNOWN as 2'b10. The code 2'b11 never appears.
- R10: A line change driven between clock edges appears on state_o and on the pulses after the third rising edge: two synchronizer stages and one state register.
- R11: An SDA change while SCL is low, or an SCL pulse with SDA steady, changes neither the FREE or BUSY state nor either pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| all_reset_i | input | 1 | 1: whole bus reset together; 0: this device reset alone |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| req_i | input | 1 | Local master asks to begin a transaction |
| grant_o | output | 1 | Registered permission to begin |
| state_o | output | 2 | Bus state: 00 FREE, 01 BUSY, 10 UNKNOWN |
| start_pulse_o | output | 1 | One-cycle pulse per START |
| stop_pulse_o | output | 1 | One-cycle pulse per STOP |

## Verification
Suppose the previous-sample register or the window counter were wrong inside the block. At the ports this would show as a phantom or a missed START or STOP pulse, or as an UNKNOWN state that settles on the wrong edge. Every such fault becomes visible three clock edges after the offending line change, or on the edge where the window should close.

The bench sweeps the SCL-edge arrival point across the whole window and past its end, so an off-by-one in the window length shows up as a wrong final state at the boundary offset. A stuck or late grant appears as a mismatch between grant_o and state_o in the same sample.

// File: rtl/i2c_bus_watch_pkg.sv
`timescale 1ns/1ps
package i2c_bus_watch_pkg;
  typedef enum logic [1:0] {
    BUS_FREE    = 2'b00,
    BUS_BUSY    = 2'b01,
    BUS_UNKNOWN = 2'b10
  } bus_state_e;
endpackage

// File: rtl/i2c_bus_watch_sync.sv
`timescale 1ns/1ps
module i2c_bus_watch_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    // no reset: chain fills while reset is held, so release sees no false edge
    always_ff @(posedge clk_i) chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/i2c_bus_watch_detect.sv
`timescale 1ns/1ps
module i2c_bus_watch_detect (
  input  logic clk_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_edge_o
);
  logic scl_prev_q, sda_prev_q;

  always_ff @(posedge clk_i) begin
    scl_prev_q <= scl_i;
    sda_prev_q <= sda_i;
  end

  logic scl_held;
  assign scl_held   = scl_prev_q & scl_i;
  assign start_o    = scl_held & sda_prev_q & ~sda_i;
  assign stop_o     = scl_held & ~sda_prev_q & sda_i;
  assign scl_edge_o = scl_prev_q ^ scl_i;
endmodule

// File: rtl/i2c_bus_watch_fsm.sv
`timescale 1ns/1ps
module i2c_bus_watch_fsm
  import i2c_bus_watch_pkg::*;
#(
  parameter int WIN_CYCLES = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       all_reset_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       scl_edge_i,
  input  logic       req_i,
  output logic [1:0] state_o,
  output logic       grant_o,
  output logic       start_pulse_o,
  output logic       stop_pulse_o
);
  localparam int CW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

  bus_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic grant_q, start_q, stop_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (start_i)       state_d = BUS_BUSY;
    else if (stop_i)   state_d = BUS_FREE;
    else if (state_q == BUS_UNKNOWN) begin
      if (scl_edge_i)        state_d = BUS_BUSY;
      else if (cnt_q == LAST) state_d = BUS_FREE;
      else                   cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= all_reset_i ? BUS_FREE : BUS_UNKNOWN;
      cnt_q   <= '0;
      grant_q <= 1'b0;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      grant_q <= req_i && (state_d == BUS_FREE);
      start_q <= start_i;
      stop_q  <= stop_i;
    end
  end

  assign state_o       = state_q;
  assign grant_o       = grant_q;
  assign start_pulse_o = start_q;
  assign stop_pulse_o  = stop_q;
endmodule

// File: rtl/i2c_bus_watch.sv
`timescale 1ns/1ps
module i2c_bus_watch #(
  parameter int WIN_CYCLES  = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       all_reset_i,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       req_i,
  output logic       grant_o,
  output logic [1:0] state_o,
  output logic       start_pulse_o,
  output logic       stop_pulse_o
);
  logic [1:0] lines_s;
  logic start_w, stop_w, scl_edge_w;

  i2c_bus_watch_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .d_i   ({scl_i, sda_i}),
    .q_o   (lines_s)
  );

  i2c_bus_watch_detect u_detect (
    .clk_i      (clk_i),
    .scl_i      (lines_s[1]),
    .sda_i      (lines_s[0]),
    .start_o    (start_w),
    .stop_o     (stop_w),
    .scl_edge_o (scl_edge_w)
  );

  i2c_bus_watch_fsm #(.WIN_CYCLES(WIN_CYCLES)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .all_reset_i   (all_reset_i),
    .start_i       (start_w),
    .stop_i        (stop_w),
    .scl_edge_i    (scl_edge_w),
    .req_i         (req_i),
    .state_o       (state_o),
    .grant_o       (grant_o),
    .start_pulse_o (start_pulse_o),
    .stop_pulse_o  (stop_pulse_o)
  );
endmodule

// File: rtl/i2c_bus_watch_checker.sv
`timescale 1ns/1ps
module i2c_bus_watch_checker #(
  parameter int WIN_CYCLES = 1000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       grant_o,
  input logic [1:0] state_o,
  input logic       start_pulse_o,
  input logic       stop_pulse_o
);
  int unsigned unk_cycles;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) unk_cycles <= 0;
    else if (state_o == 2'b10 && unk_cycles < WIN_CYCLES + 1) unk_cycles <= unk_cycles + 1;
  end

  assert_state_legal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'b11);
  assert_start_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_pulse_o |-> state_o == 2'b01);
  assert_start_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_pulse_o |=> !start_pulse_o);
  assert_stop_free_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_pulse_o |-> state_o == 2'b00);
  assert_stop_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_pulse_o |=> !stop_pulse_o);
  assert_pulse_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_pulse_o, stop_pulse_o}));
  assert_grant_free_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> state_o == 2'b00);
  assert_grant_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> $past(req_i));
  assert_no_reenter_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'b10 |=> state_o != 2'b10);
  assert_window_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'b10 |-> unk_cycles < WIN_CYCLES);
endmodule

bind i2c_bus_watch i2c_bus_watch_checker #(.WIN_CYCLES(WIN_CYCLES)) u_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_i         (req_i),
  .grant_o       (grant_o),
  .state_o       (state_o),
  .start_pulse_o (start_pulse_o),
  .stop_pulse_o  (stop_pulse_o)
);

// File: tb/test_i2c_bus_watch.sv
`timescale 1ns/1ps
module test_i2c_bus_watch;
  localparam int WIN = 12;
  localparam logic [1:0] ST_FREE = 2'b00, ST_BUSY = 2'b01, ST_UNK = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic all_reset = 1'b1;
  logic scl = 1'b1, sda = 1'b1, req = 1'b0;
  logic grant, start_p, stop_p;
  logic [1:0] state;

  int checks = 0, errors = 0;
  int n_start = 0, n_stop = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_bus_watch #(.WIN_CYCLES(WIN), .SYNC_STAGES(2)) i_i2c_bus_watch (
    .clk_i(clk), .rst_ni(rst_n), .all_reset_i(all_reset), .scl_i(scl), .sda_i(sda),
    .req_i(req), .grant_o(grant), .state_o(state),
    .start_pulse_o(start_p), .stop_pulse_o(stop_p)
  );

  always @(negedge clk) begin
    if (start_p) n_start++;
    if (stop_p)  n_stop++;
  end

  task automatic check(input string req_tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  // drive lines at a negedge, sample just after the third rising edge
  task automatic apply(input logic c, input logic d);
    @(negedge clk);
    scl = c; sda = d;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    all_reset = mode;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int s0, p0, cnt;
    // R3 reset into FREE
    repeat (3) @(posedge clk); #1;
    check("R3 state in reset", state, ST_FREE);
    check("R8 grant in reset", grant, 0);
    @(negedge clk); rst_n = 1'b1;
    req = 1'b1;
    repeat (2) @(posedge clk); #1;
    check("R3 state after release", state, ST_FREE);
    check("R8 grant with req in FREE", grant, 1);

    // R1/R10 START with latency
    s0 = n_start;
    @(negedge clk); sda = 1'b0;
    repeat (2) @(posedge clk); #1;
    check("R10 state before third edge", state, ST_FREE);
    @(posedge clk); #1;
    check("R1 START to BUSY", state, ST_BUSY);
    check("R8 grant drops with state", grant, 0);
    check("R1 start pulse high", start_p, 1);
    @(posedge clk); #1;
    check("R1 start pulse one cycle", start_p, 0);
    check("R1 start pulse count", n_start - s0, 1);

    // R11 data bits while BUSY
    s0 = n_start; p0 = n_stop;
    apply(1'b0, 1'b0); apply(1'b0, 1'b1); apply(1'b1, 1'b1); apply(1'b0, 1'b1);
    apply(1'b0, 1'b0); apply(1'b1, 1'b0);
    check("R11 BUSY kept by data bits", state, ST_BUSY);
    check("R11 no pulses in BUSY data", (n_start - s0) + (n_stop - p0), 0);
    check("R8 no grant while BUSY", grant, 0);

    // R2 STOP
    apply(1'b1, 1'b1);
    check("R2 STOP to FREE", state, ST_FREE);
    check("R8 grant rises with FREE", grant, 1);
    check("R2 stop pulse high", stop_p, 1);
    @(posedge clk); #1;
    check("R2 stop pulse one cycle", stop_p, 0);
    check("R2 stop pulse count", n_stop - p0, 1);

    // R11 data bits while FREE
    s0 = n_start; p0 = n_stop;
    apply(1'b0, 1'b1); apply(1'b0, 1'b0); apply(1'b1, 1'b0); apply(1'b0, 1'b0);
    apply(1'b0, 1'b1); apply(1'b1, 1'b1);
    check("R11 FREE kept by data bits", state, ST_FREE);
    check("R11 no pulses in FREE data", (n_start - s0) + (n_stop - p0), 0);
    req = 1'b0;
    @(posedge clk); #1;
    check("R8 no grant without req", grant, 0);
    req = 1'b1;

    // R4/R5 local reset, quiet window
    @(negedge clk); all_reset = 1'b0; rst_n = 1'b0;
    repeat (2) @(posedge clk); #1;
    check("R4 UNKNOWN in reset", state, ST_UNK);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    cnt = 0;
    begin
      bit early_grant = 1'b0;
      while (state != ST_FREE && cnt < 4 * WIN) begin
        @(posedge clk); #1;
        cnt++;
        if (state != ST_FREE && grant) early_grant = 1'b1;
      end
      check("R8 request waits in UNKNOWN", early_grant, 0);
    end
    check("R5 quiet window length", cnt, WIN);
    check("R8 grant with FREE after window", grant, 1);

    // R7 START overrides UNKNOWN
    do_reset(1'b0);
    s0 = n_start;
    apply(1'b1, 1'b0);
    check("R7 START in UNKNOWN", state, ST_BUSY);
    check("R1 start pulse from UNKNOWN", n_start - s0 + start_p, 1);

    // R7 STOP overrides UNKNOWN (lines held scl=1 sda=0 across reset)
    do_reset(1'b0);
    apply(1'b1, 1'b1);
    check("R7 STOP in UNKNOWN early", state, ST_FREE);
    check("R2 stop pulse from UNKNOWN", stop_p, 1);

    // R3 whole-bus reset from BUSY
    apply(1'b1, 1'b0);
    check("R1 START from FREE again", state, ST_BUSY);
    do_reset(1'b1);
    @(posedge clk); #1;
    check("R3 whole-bus reset from BUSY", state, ST_FREE);
    apply(1'b1, 1'b1);
    check("R2 STOP in FREE stays FREE", state, ST_FREE);

    // R6 sweep of SCL edge position across the window
    req = 1'b0;
    for (int off = 0; off <= WIN + 1; off++) begin
      scl = 1'b1; sda = 1'b1;
      do_reset(1'b0);
      repeat (off) @(negedge clk);
      scl = 1'b0;
      repeat (WIN + 6) @(posedge clk); #1;
      check($sformatf("R6 scl edge at offset %0d", off), state,
            (off <= WIN - 3) ? ST_BUSY : ST_FREE);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule